// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This controller drives a small three-wire serial EEPROM (chip select, serial clock and one data line) on behalf of a host. The host writes a command word that names an operation and an address. The controller then shifts the framed command out bit by bit. For a read it collects the returned byte. For any operation that changes the array, it polls the device until the device reports ready. A busy bit in the command word tells the host when it may issue the next command. A timeout flag reports a device that never becomes ready.

When reset ends, the controller reads a signature byte from location 0 without being asked. If that byte is 0xA5, it reads locations 1 to 6 into a 48-bit station address. If the byte is anything else, the boot phase ends and the address stays invalid. The serial clock rate comes from a programmable half-period input. The data line is split into an output value, an output enable and an input value, and these are combined into one pad outside the block.

Top module: `uwire_prom_ctrl`

## Requirements
- R1: While reset is held, `prom_cs` and `prom_sk` are low. On the first cycle after reset is released, the busy bit (`cmd_rdata[31]`) reads 1 because the boot read has started.
- R2: If location 0 holds 0xA5, the boot phase performs seven reads (chip select rises seven times) and loads the station address with location 1 in bits 7:0 through location 6 in bits 47:40. It then sets `mac_valid` and `boot_done`.
- R3: If location 0 holds any other value, the boot phase ends after that single read. `boot_done` rises while `mac_valid` and `mac_addr` stay 0.
- R4: A write of `cmd_wdata` with bit 31 set starts the command coded in bits 30:28. The codes are READ=000, EWDS=001, EWEN=010, WRITE=011, WRAL=100, ERASE=101, ERAL=110, and 111 does nothing. The address is taken from bits 6:0. Bit 31 of `cmd_rdata` stays 1 until the command ends, and bits 30:28 read back the code.
- R5: Command and data writes made while busy is 1 are ignored.
- R6: A command frame is a start bit of 1, a 2-bit opcode and 7 address bits, sent MSB first. On the wire the opcode is 10 for a read, 01 for a write and 11 for an erase. The all-location commands use opcode 00, and address bits 6:5 are 11 for enable, 00 for disable, 10 for erase-all and 01 for write-all. READ then clocks in 8 bits, MSB first, on rising clock edges and stores them in the data register.
- R7: WRITE sends the data register byte after the address and stores it at the addressed location. WRAL stores that byte at every location.
- R8: ERASE sets the addressed location to 0xFF, and ERAL sets every location to 0xFF.
- R9: After reset or after EWDS, and until the next EWEN, the commands WRITE, WRAL, ERASE and ERAL complete at once. Busy reads 0 on the next cycle, chip select never rises, and the array is unchanged.
- R10: After an enabled write-type command, chip select drops for one half clock period and then rises again with no clock running. It stays high until the data line reads high. The command therefore raises chip select twice, and the data line is driven only while chip select is high.
- R11: If the data line does not read high within `TMO_CYCLES` clock cycles of polling, the timeout flag (`cmd_rdata[9]`) is set and busy clears. The next command start clears the flag.
- R12: The serial clock toggles only while chip select is high, and the outgoing data bit changes only while the serial clock is low.
- R13: Each high phase and each low phase of the serial clock lasts `sk_half`+1 cycles of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sk_half | input | 8 | Serial clock half period minus one, in clk cycles |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: start bit 31, code 30:28, address 6:0 |
| cmd_rdata | output | 32 | Busy 31, code 30:28, timeout 9, address 6:0 |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Byte to store for WRITE and WRAL |
| data_rdata | output | 8 | Data register, holds the result of READ |
| mac_addr | output | 48 | Station address loaded during boot |
| mac_valid | output | 1 | Signature matched and the address is loaded |
| boot_done | output | 1 | Boot phase finished |
| prom_cs | output | 1 | EEPROM chip select |
| prom_sk | output | 1 | EEPROM serial clock |
| prom_dio_out | output | 1 | Data line output value |
| prom_dio_oe | output | 1 | Data line output enable |
| prom_dio_in | input | 1 | Data line input value |

## Verification
The bench attaches a behavioural EEPROM model and goes after the corners where a faulty controller fails quietly. A write issued before enable or after disable must leave chip select untouched. A controller that sends it anyway would corrupt the array. A device that never reports ready must end in the timeout flag. A controller that leaves out the poll bound would hang busy forever. A command written while busy must not change the code or the data register. A faulty design would overwrite the read result. The boot phase is run with a good and a bad signature: an off-by-one in the byte placement shows up as a shifted station address, and a missing signature gate shows up as extra reads.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int FRAME_W   = 3 + ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int MAC_BYTES = 6;
    localparam int BIDX_W    = $clog2(MAC_BYTES + 1);
    localparam logic [DATA_W-1:0] SIGNATURE = 8'hA5;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_EWDS  = 3'd1,
        CMD_EWEN  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_WRAL  = 3'd4,
        CMD_ERASE = 3'd5,
        CMD_ERAL  = 3'd6,
        CMD_NOP   = 3'd7
    } ucmd_e;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_POLL} ustate_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // left aligned, MSB goes out first
        logic [CNT_W-1:0]   nout;   // bits driven, 0 means no wire activity
        logic [CNT_W-1:0]   nin;    // bits sampled after the driven ones
        logic               poll;   // device must be polled for ready
        logic               gated;  // needs the write enable latch
    } uframe_t;

    function automatic uframe_t build_frame(ucmd_e c, logic [ADDR_W-1:0] a,
                                            logic [DATA_W-1:0] d);
        uframe_t f;
        logic [1:0] op;
        logic [ADDR_W-1:0] ad;
        logic with_data;
        logic valid;
        f = '0;
        op = 2'b00;
        ad = a;
        with_data = 1'b0;
        valid = 1'b1;
        case (c)
            CMD_READ:  begin op = 2'b10; f.nin = CNT_W'(DATA_W); end
            CMD_EWDS:  ad = {2'b00, {(ADDR_W-2){1'b0}}};
            CMD_EWEN:  ad = {2'b11, {(ADDR_W-2){1'b0}}};
            CMD_WRITE: begin op = 2'b01; with_data = 1'b1; f.poll = 1'b1; f.gated = 1'b1; end
            CMD_WRAL:  begin ad = {2'b01, {(ADDR_W-2){1'b0}}}; with_data = 1'b1;
                             f.poll = 1'b1; f.gated = 1'b1; end
            CMD_ERASE: begin op = 2'b11; f.poll = 1'b1; f.gated = 1'b1; end
            CMD_ERAL:  begin ad = {2'b10, {(ADDR_W-2){1'b0}}}; f.poll = 1'b1; f.gated = 1'b1; end
            default:   valid = 1'b0;
        endcase
        f.bits = {1'b1, op, ad, (with_data ? d : {DATA_W{1'b0}})};
        if (valid)
            f.nout = with_data ? CNT_W'(FRAME_W) : CNT_W'(3 + ADDR_W);
        return f;
    endfunction

endpackage

// File: rtl/uwire_clkdiv.sv
module uwire_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == half);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // R13
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $stable(half)) |-> (cnt_q <= half));

endmodule

// File: rtl/uwire_shift.sv
module uwire_shift
    import uwire_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] bits,
    input  logic [CNT_W-1:0]   nout,
    input  logic [CNT_W-1:0]   nin,
    input  logic               tick,
    input  logic               din,
    output logic               sk,
    output logic               dout,
    output logic               oe,
    output logic               active,
    output logic               done,
    output logic [DATA_W-1:0]  rx
);
    logic [FRAME_W-1:0] sreg_q;
    logic [CNT_W-1:0]   idx_q, nout_q, last_q;
    logic               act_q, sk_q;
    logic [DATA_W-1:0]  rx_q;
    logic               out_phase;

    assign out_phase = idx_q < nout_q;
    assign done      = act_q && tick && sk_q && (idx_q == last_q);
    assign sk        = sk_q;
    assign dout      = act_q && out_phase && sreg_q[FRAME_W-1];
    assign oe        = act_q && out_phase;
    assign active    = act_q;
    assign rx        = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0; idx_q <= '0; nout_q <= '0; last_q <= '0;
            act_q <= 1'b0; sk_q <= 1'b0; rx_q <= '0;
        end else if (start) begin
            act_q  <= 1'b1;
            sk_q   <= 1'b0;
            sreg_q <= bits;
            idx_q  <= '0;
            nout_q <= nout;
            last_q <= nout + nin - 1'b1;
        end else if (act_q && tick) begin
            if (!sk_q) begin
                sk_q <= 1'b1;                       // rising edge: sample
                if (!out_phase) rx_q <= {rx_q[DATA_W-2:0], din};
            end else begin
                sk_q <= 1'b0;                       // falling edge: advance
                if (idx_q == last_q) act_q <= 1'b0;
                else begin
                    idx_q  <= idx_q + 1'b1;
                    sreg_q <= sreg_q << 1;
                end
            end
        end
    end

    // R12
    dout_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> !sk_q);

endmodule

// File: rtl/uwire_prom_ctrl.sv
module uwire_prom_ctrl
    import uwire_pkg::*;
#(
    parameter int TMO_CYCLES = 7_500_000,   // 30 ms of a 250 MHz clk
    parameter int DIV_W      = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DIV_W-1:0]         sk_half,
    input  logic                     cmd_wr,
    input  logic [31:0]              cmd_wdata,
    output logic [31:0]              cmd_rdata,
    input  logic                     data_wr,
    input  logic [DATA_W-1:0]        data_wdata,
    output logic [DATA_W-1:0]        data_rdata,
    output logic [8*MAC_BYTES-1:0]   mac_addr,
    output logic                     mac_valid,
    output logic                     boot_done,
    output logic                     prom_cs,
    output logic                     prom_sk,
    output logic                     prom_dio_out,
    output logic                     prom_dio_oe,
    input  logic                     prom_dio_in
);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);

    ustate_e             state_q;
    logic                booting_q, boot_done_q, mac_valid_q, tmo_q, wen_q, cs_q, poll_q;
    logic [BIDX_W-1:0]   boot_idx_q;
    logic [8*MAC_BYTES-1:0] mac_q;
    ucmd_e               cmd_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [TMO_W-1:0]    poll_cnt_q;

    ucmd_e               req_cmd;
    logic [ADDR_W-1:0]   req_addr;
    uframe_t             req_fr;
    logic                host_go, launch, busy, tick, sh_done, sh_active;
    logic [DATA_W-1:0]   sh_rx;
    logic                unused_bits;

    assign unused_bits = ^cmd_wdata[27:ADDR_W];
    assign busy = booting_q || (state_q != ST_IDLE);

    always_comb begin
        req_cmd  = booting_q ? CMD_READ : ucmd_e'(cmd_wdata[30:28]);
        req_addr = booting_q ? ADDR_W'(boot_idx_q) : cmd_wdata[ADDR_W-1:0];
        req_fr   = build_frame(req_cmd, req_addr, data_q);
        host_go  = !booting_q && cmd_wr && cmd_wdata[31];
        launch   = (state_q == ST_IDLE) &&
                   (booting_q || (host_go && (req_fr.nout != '0) && !(req_fr.gated && !wen_q)));
    end

    uwire_clkdiv #(.DIV_W(DIV_W)) div_i (
        .clk(clk), .rst(rst), .en((state_q == ST_SHIFT) || (state_q == ST_GAP)),
        .half(sk_half), .tick(tick));

    uwire_shift shift_i (
        .clk(clk), .rst(rst), .start(launch), .bits(req_fr.bits), .nout(req_fr.nout),
        .nin(req_fr.nin), .tick(tick), .din(prom_dio_in), .sk(prom_sk),
        .dout(prom_dio_out), .oe(prom_dio_oe), .active(sh_active), .done(sh_done), .rx(sh_rx));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE; booting_q <= 1'b1; boot_idx_q <= '0; boot_done_q <= 1'b0;
            mac_valid_q <= 1'b0; mac_q <= '0; cmd_q <= CMD_READ; addr_q <= '0;
            data_q <= '0; tmo_q <= 1'b0; wen_q <= 1'b0; cs_q <= 1'b0; poll_q <= 1'b0;
            poll_cnt_q <= '0;
        end else begin
            if (data_wr && !busy) data_q <= data_wdata;
            case (state_q)
                ST_IDLE: begin
                    if (host_go) begin
                        cmd_q  <= req_cmd;
                        addr_q <= req_addr;
                        tmo_q  <= 1'b0;
                    end
                    if (launch) begin
                        cs_q    <= 1'b1;
                        poll_q  <= req_fr.poll;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: if (sh_done) begin
                    cs_q    <= 1'b0;
                    state_q <= ST_GAP;
                    if (booting_q) begin
                        for (int i = 0; i < MAC_BYTES; i++)
                            if (boot_idx_q == BIDX_W'(i + 1)) mac_q[8*i +: 8] <= sh_rx;
                        if ((boot_idx_q == '0 && sh_rx != SIGNATURE) ||
                            boot_idx_q == BIDX_W'(MAC_BYTES)) begin
                            booting_q   <= 1'b0;
                            boot_done_q <= 1'b1;
                            mac_valid_q <= (boot_idx_q != '0);
                        end
                        boot_idx_q <= boot_idx_q + 1'b1;
                    end else begin
                        if (cmd_q == CMD_READ) data_q <= sh_rx;
                        if (cmd_q == CMD_EWEN) wen_q <= 1'b1;
                        if (cmd_q == CMD_EWDS) wen_q <= 1'b0;
                    end
                end
                ST_GAP: if (tick) begin
                    if (poll_q) begin
                        cs_q       <= 1'b1;
                        poll_cnt_q <= '0;
                        state_q    <= ST_POLL;
                    end else state_q <= ST_IDLE;
                end
                default: begin
                    if (prom_dio_in) begin
                        cs_q <= 1'b0; state_q <= ST_IDLE;
                    end else if (poll_cnt_q == TMO_W'(TMO_CYCLES - 1)) begin
                        tmo_q <= 1'b1; cs_q <= 1'b0; state_q <= ST_IDLE;
                    end else poll_cnt_q <= poll_cnt_q + 1'b1;
                end
            endcase
        end
    end

    assign prom_cs    = cs_q;
    assign data_rdata = data_q;
    assign mac_addr   = mac_q;
    assign mac_valid  = mac_valid_q;
    assign boot_done  = boot_done_q;
    assign cmd_rdata  = {busy, cmd_q, 18'd0, tmo_q, 2'b00, addr_q};

    // R10
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        prom_dio_oe |-> prom_cs);
    // R12
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (prom_sk || sh_active) |-> prom_cs);
    // R11
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        poll_cnt_q < TMO_W'(TMO_CYCLES));
    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> ($stable(cmd_q) && $stable(addr_q)));
    // R2
    valid_after_boot_chk: assert property (@(posedge clk) disable iff (rst)
        mac_valid |-> boot_done);

endmodule

// File: tb/uwire_prom_ctrl_tb.sv
module uwire_prom_ctrl_tb_top;
    localparam int TMO = 3000;
    localparam int WR_T = 200;

    logic clk = 1'b0, rst = 1'b1;
    logic [7:0] sk_half = 8'd2;
    logic cmd_wr = 1'b0, data_wr = 1'b0;
    logic [31:0] cmd_wdata = '0, cmd_rdata;
    logic [7:0] data_wdata = '0, data_rdata;
    logic [47:0] mac_addr;
    logic mac_valid, boot_done, prom_cs, prom_sk, prom_dio_out, prom_dio_oe, prom_dio_in;

    always #2 clk = ~clk;

    uwire_prom_ctrl #(.TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst(rst), .sk_half(sk_half), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rdata(data_rdata), .mac_addr(mac_addr), .mac_valid(mac_valid),
        .boot_done(boot_done), .prom_cs(prom_cs), .prom_sk(prom_sk),
        .prom_dio_out(prom_dio_out), .prom_dio_oe(prom_dio_oe), .prom_dio_in(prom_dio_in));

    // ---------------- behavioural EEPROM ----------------
    logic [7:0] mem [128];
    logic [7:0] exp_mem [128];
    logic [16:0] sh = '0;
    logic started = 1'b0, rd_mode = 1'b0, rbit = 1'b0, poll_pend = 1'b0, dead = 1'b0;
    logic [7:0] rbyte = '0;
    int cnt = 0, rk = 0, ready_at = 0, cyc = 0, cs_rises = 0, hi_run = 0, hi_len = 0;

    assign prom_dio_in = prom_cs && (rd_mode ? rbit : (poll_pend && !dead && cyc >= ready_at));

    always @(posedge clk) begin
        cyc++;
        if (prom_sk) hi_run++;
        else begin
            if (hi_run != 0) hi_len = hi_run;
            hi_run = 0;
        end
    end

    always @(posedge prom_cs) begin
        started = 1'b0; cnt = 0; rd_mode = 1'b0; rk = 0; cs_rises++;
    end

    always @(posedge prom_sk) if (prom_cs) begin
        if (!started) begin
            if (prom_dio_out) started = 1'b1;
        end else begin
            sh = {sh[15:0], prom_dio_out};
            cnt++;
            if (cnt == 9 && sh[8:7] == 2'b10) begin
                rd_mode = 1'b1; rbyte = mem[sh[6:0]];
            end
        end
    end

    always @(negedge prom_sk) if (rd_mode && rk < 8) begin
        rbit = rbyte[7-rk]; rk++;
    end

    always @(negedge prom_cs) begin : exec_blk
        logic [1:0] op; logic [6:0] a; logic [7:0] d; logic wr;
        wr = 1'b0; op = 2'b00; a = '0; d = '0;
        if (started && cnt >= 9) begin
            if (cnt >= 17) begin op = sh[16:15]; a = sh[14:8]; d = sh[7:0]; end
            else begin op = sh[8:7]; a = sh[6:0]; end
            case (op)
                2'b01: if (cnt >= 17) begin mem[a] = d; wr = 1'b1; end
                2'b11: begin mem[a] = 8'hFF; wr = 1'b1; end
                2'b00: case (a[6:5])
                    2'b10: begin for (int i = 0; i < 128; i++) mem[i] = 8'hFF; wr = 1'b1; end
                    2'b01: if (cnt >= 17) begin
                        for (int i = 0; i < 128; i++) mem[i] = d; wr = 1'b1; end
                    default: ;
                endcase
                default: ;
            endcase
        end
        poll_pend = wr; ready_at = cyc + WR_T; rd_mode = 1'b0; started = 1'b0;
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;
    logic finished = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wait_idle();
        while (cmd_rdata[31]) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] c, input logic [6:0] a);
        @(negedge clk);
        cmd_wdata = {1'b1, c, 21'd0, a}; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic host_cmd(input logic [2:0] c, input logic [6:0] a);
        issue(c, a); wait_idle();
    endtask

    task automatic set_data(input logic [7:0] d);
        @(negedge clk); data_wdata = d; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [6:0] a);
        host_cmd(3'd0, a);
        chk(tag, data_rdata, exp_mem[a]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cs low in reset", prom_cs, 1'b0);
        chk("R1 sk low in reset", prom_sk, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", cmd_rdata[31], 1'b1);
        while (!boot_done) @(negedge clk);
        wait_idle();
    endtask

    function automatic logic [47:0] exp_mac();
        logic [47:0] m;
        for (int i = 0; i < 6; i++) m[8*i +: 8] = exp_mem[i+1];
        return m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0, t0;
        logic [6:0] a;
        logic [7:0] d;
        void'($urandom(32'd7));
        for (int i = 0; i < 128; i++) begin mem[i] = 8'($urandom); exp_mem[i] = mem[i]; end
        mem[0] = 8'hA5; exp_mem[0] = 8'hA5;

        // R1, R2: good signature boot
        c0 = cs_rises;
        do_reset();
        chk("R2 mac_valid", mac_valid, 1'b1);
        chk("R2 mac bytes", mac_addr, exp_mac());
        chk("R2 boot read count", cs_rises - c0, 7);

        // R9: write before enable is dropped
        set_data(8'h3C);
        c0 = cs_rises;
        issue(3'd3, 7'd10);
        chk("R9 busy clear at once", cmd_rdata[31], 1'b0);
        wait_idle();
        chk("R9 no chip select", cs_rises - c0, 0);
        read_chk("R9 contents kept", 7'd10);

        // R4, R10, R6, R7: enabled writes and read back
        host_cmd(3'd2, 7'd0);
        for (int k = 0; k < 10; k++) begin
            a = 7'(8 + $urandom_range(0, 100)); d = 8'($urandom);
            set_data(d);
            c0 = cs_rises;
            issue(3'd3, a);
            if (k == 0) begin
                chk("R4 busy set", cmd_rdata[31], 1'b1);
                chk("R4 code readback", cmd_rdata[30:28], 3'd3);
                chk("R4 addr readback", cmd_rdata[6:0], a);
            end
            wait_idle();
            exp_mem[a] = d;
            chk("R10 two selects per write", cs_rises - c0, 2);
            read_chk("R6 R7 write then read", a);
        end
        chk("R13 sk high phase", hi_len, 3);

        // R8: erase one location
        host_cmd(3'd5, 7'd15); exp_mem[15] = 8'hFF;
        read_chk("R8 erase", 7'd15);

        // R7: write all
        set_data(8'h5A); host_cmd(3'd4, 7'd0);
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'h5A;
        read_chk("R7 wral lo", 7'd0);
        read_chk("R7 wral hi", 7'd127);
        read_chk("R7 wral mid", 7'(50 + $urandom_range(0, 20)));

        // R8: erase all
        host_cmd(3'd6, 7'd0);
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
        read_chk("R8 eral a", 7'd3);
        read_chk("R8 eral b", 7'd99);

        // R5: writes while busy are ignored
        set_data(8'h11); host_cmd(3'd3, 7'd20); exp_mem[20] = 8'h11;
        issue(3'd0, 7'd20);
        @(negedge clk);
        cmd_wdata = {1'b1, 3'd3, 21'd0, 7'd33}; cmd_wr = 1'b1; data_wdata = 8'h77; data_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; data_wr = 1'b0;
        wait_idle();
        chk("R5 code kept", cmd_rdata[30:28], 3'd0);
        chk("R5 addr kept", cmd_rdata[6:0], 7'd20);
        chk("R5 data is read result", data_rdata, 8'h11);

        // R11: device never ready
        dead = 1'b1;
        set_data(8'h42);
        t0 = cyc;
        host_cmd(3'd3, 7'd30); exp_mem[30] = 8'h42;
        dead = 1'b0;
        chk("R11 timeout flag", cmd_rdata[9], 1'b1);
        chk("R11 waited long enough", (cyc - t0) >= TMO, 1'b1);
        read_chk("R11 read after timeout", 7'd30);
        chk("R11 flag cleared", cmd_rdata[9], 1'b0);

        // R9: disable then write is dropped
        host_cmd(3'd1, 7'd0);
        set_data(8'h99);
        c0 = cs_rises;
        host_cmd(3'd3, 7'd40);
        chk("R9 no select after disable", cs_rises - c0, 0);
        read_chk("R9 kept after disable", 7'd40);

        // R3: bad signature
        mem[0] = 8'h5A;
        c0 = cs_rises;
        do_reset();
        chk("R3 mac_valid low", mac_valid, 1'b0);
        chk("R3 mac zero", mac_addr, 48'd0);
        chk("R3 single boot read", cs_rises - c0, 1);
        chk("R3 boot_done", boot_done, 1'b1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule